// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block watches every bus cycle of a processor that uses an asynchronous address-strobe / transfer-acknowledge handshake. A cycle opens when the active-low address strobe goes low. A responder closes it by pulling the shared, pulled-up, active-low acknowledge line low. The block gives no cycle a fixed length. If a cycle stays open for a set time with no acknowledge, the block drives the active-low bus-error line so the processor can abort the access and recover. It does not reset anything.

Both handshake inputs come from outside the clock domain, so each passes through a two-flop synchronizer before any logic uses it. A counter runs while a synchronized cycle is open and no acknowledge has been seen. The limit is worked out at elaboration from two parameters: the clock frequency in hertz and the limit in microseconds. The defaults are 10 MHz and 10 µs, which gives 100 clocks. Below, N is that limit in clocks.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: If the acknowledge input goes low early in a cycle and stays low, bus error never asserts, however long the strobe then stays low.
- R2: With the strobe held low from a falling edge and no acknowledge, `berr_n` is still high N+2 rising edges later and goes low at rising edge N+3. Edges are counted from the clock edge that follows the change. N = (CLK_HZ / 1,000,000) × LIMIT_US.
- R3: If the acknowledge input falls d clocks after the strobe, with d ≤ N−1, bus error does not assert. If d = N, bus error asserts at edge N+3 as in R2.
- R4: Once asserted, `berr_n` stays low while the strobe stays low, including after the acknowledge input goes low.
- R5: When the strobe returns high, `berr_n` is still low two edges later and high three edges later.
- R6: After a release, the next cycle times out again with the full latency of R2.
- R7: While `rst_n` is low, `berr_n` is high from the first rising edge on, whatever the inputs do. This includes a bus error that was already asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe from the processor, active low, asynchronous |
| dtack_n | input | 1 | Transfer acknowledge, wired-OR from responders, active low, asynchronous |
| berr_n | output | 1 | Bus-error request to the processor, active low |

## Verification
Every result has a fixed latency, counted in rising edges from the input change:
- Bus error asserts N+3 edges after the strobe falls: two synchronizer stages, N counting steps, then one edge for the error flag.
- It releases three edges after the strobe rises.
- It clears one edge after reset is applied.

The driver records the edge count at the moment it changes an input. It then queues expected values tagged with the exact edge after which they are due. This includes the value one edge before each transition, so an early or late output is caught. The monitor samples at the falling edge and compares each item only in the cycle it is due.

// File: rtl/bcw_pkg.sv
// Package: shared constants and helpers for the bus cycle watchdog.
// Assumes the clock frequency is a whole number of megahertz.
package bcw_pkg;

    // Synchronizer depth applied to both handshake inputs.
    localparam int unsigned SYNC_STAGES = 2;

    // Convert clock frequency and limit in microseconds into a clock count (at least 1).
    function automatic int unsigned limit_clks(input int unsigned hz, input int unsigned us);
        int unsigned n;
        n = (hz / 32'd1_000_000) * us;
        return (n == 0) ? 32'd1 : n;
    endfunction

endpackage

// File: rtl/bcw_sync.sv
// Module: bcw_sync
// Multi-stage flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2. In reset every stage takes the IDLE level, so the
// output shows the inactive state until real samples arrive.
module bcw_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage;

    // First stage samples the raw asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= IDLE;
        else        stage[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_chain
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= IDLE;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/bcw_timer.sv
// Module: bcw_timer
// Counts clocks while a bus cycle is open and unacknowledged.
// Saturates at LIMIT and flags expiry there. Clears whenever the strobe is
// idle or an acknowledge is seen. Inputs are assumed already synchronized.
module bcw_timer #(
    parameter int unsigned LIMIT = 100,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_idle,
    input  logic ack_seen,
    output logic expired
);

    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Advance the cycle age, clearing it on idle strobe or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (as_idle || ack_seen) cnt <= '0;
        else if (cnt != LIM_V)        cnt <= cnt + ONE_V;
    end

    assign expired = (cnt == LIM_V);

    // R1
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> (cnt == '0));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_idle && !ack_seen && !expired) |=> (cnt == $past(cnt) + ONE_V));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !as_idle && !ack_seen) |=> expired);

endmodule

// File: rtl/bcw_flag.sv
// Module: bcw_flag
// Holds the bus-error request. It sets on timer expiry and stays set until
// the synchronized strobe goes idle. An acknowledge does not clear it.
module bcw_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic as_idle,
    input  logic expired,
    output logic err_q
);

    // Set on expiry, hold through the cycle, drop once the strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (as_idle) err_q <= 1'b0;
        else if (expired) err_q <= 1'b1;
    end

    // R2
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(expired));

    // R4
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !as_idle) |=> err_q);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_idle |=> !err_q);

endmodule

// File: rtl/bus_cycle_watchdog.sv
// Module: bus_cycle_watchdog (top)
// Requests a bus error when an asynchronous bus cycle stays open beyond a
// limit with no transfer acknowledge. The limit is derived from CLK_HZ and
// LIMIT_US. Assumes the acknowledge line idles high through a pull-up.
module bus_cycle_watchdog #(
    parameter int unsigned CLK_HZ   = 10_000_000,
    parameter int unsigned LIMIT_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic dtack_n,
    output logic berr_n
);

    localparam int unsigned LIMIT = bcw_pkg::limit_clks(CLK_HZ, LIMIT_US);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic as_s;
    logic dtack_s;
    logic expired;
    logic err_q;

    bcw_sync #(.STAGES(bcw_pkg::SYNC_STAGES), .IDLE(1'b1)) u_as_sync (
        .clk(clk), .rst_n(rst_n), .d(as_n), .q(as_s)
    );

    bcw_sync #(.STAGES(bcw_pkg::SYNC_STAGES), .IDLE(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(dtack_n), .q(dtack_s)
    );

    bcw_timer #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .as_idle(as_s), .ack_seen(!dtack_s),
        .expired(expired)
    );

    bcw_flag u_flag (
        .clk(clk), .rst_n(rst_n), .as_idle(as_s), .expired(expired),
        .err_q(err_q)
    );

    assign berr_n = !err_q;

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> berr_n);

endmodule

// File: tb/bus_cycle_watchdog_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected berr_n values keyed by
// rising-edge count; a falling-edge monitor compares them when due.
module bus_cycle_watchdog_test;

    localparam int unsigned CLK_HZ   = 1_000_000;
    localparam int unsigned LIMIT_US = 10;
    localparam longint      N        = (CLK_HZ / 1_000_000) * LIMIT_US;

    typedef struct {
        longint at;
        logic   exp;
        string  tag;
    } item_t;

    logic   clk = 1'b0;
    logic   rst_n = 1'b0;
    logic   as_n = 1'b0;
    logic   dtack_n = 1'b1;
    logic   berr_n;
    longint edges = 0;
    int     compared = 0;
    int     mismatched = 0;
    bit     done = 0;
    item_t  sbq[$];

    bus_cycle_watchdog #(.CLK_HZ(CLK_HZ), .LIMIT_US(LIMIT_US)) uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .dtack_n(dtack_n), .berr_n(berr_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) edges <= edges + 1;

    // Queue an expected value due after rising edge number 'at'.
    task automatic push(input longint at, input logic v, input string tag);
        item_t it;
        it.at = at; it.exp = v; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due items at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= edges) begin
            item_t it;
            it = sbq.pop_front();
            compared++;
            if (it.at != edges || berr_n !== it.exp) begin
                mismatched++;
                $display("FAIL %s: edge %0d berr_n actual %b expected %b (due edge %0d)",
                         it.tag, edges, berr_n, it.exp, it.at);
            end
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        longint b;
        // R7: reset holds berr_n high even with the strobe low
        @(negedge clk);
        b = edges;
        for (int k = 1; k <= 5; k++) push(b + k, 1'b1, "R7");
        wait_clks(8);
        as_n = 1'b1;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(4);

        // R2: exact trip latency
        as_n = 1'b0; b = edges;
        push(b + N + 2, 1'b1, "R2");
        push(b + N + 3, 1'b0, "R2");
        wait_clks(int'(N) + 6);

        // R4: acknowledge after trip does not release
        dtack_n = 1'b0; b = edges;
        push(b + 4, 1'b0, "R4");
        push(b + 3 * N, 1'b0, "R4");
        wait_clks(3 * int'(N) + 2);

        // R5: release three edges after strobe rises
        as_n = 1'b1; dtack_n = 1'b1; b = edges;
        push(b + 2, 1'b0, "R5");
        push(b + 3, 1'b1, "R5");
        wait_clks(6);

        // R6: next cycle rearms with full latency
        as_n = 1'b0; b = edges;
        push(b + N + 2, 1'b1, "R6");
        push(b + N + 3, 1'b0, "R6");
        wait_clks(int'(N) + 6);
        as_n = 1'b1; b = edges;
        push(b + 3, 1'b1, "R6");
        wait_clks(6);

        // R1: normal acknowledged cycle held open long
        as_n = 1'b0;
        wait_clks(4);
        dtack_n = 1'b0; b = edges;
        push(b + N, 1'b1, "R1");
        push(b + 2 * N, 1'b1, "R1");
        push(b + 4 * N, 1'b1, "R1");
        wait_clks(4 * int'(N) + 2);
        as_n = 1'b1; dtack_n = 1'b1;
        wait_clks(6);

        // R3: acknowledge at d = N-1 does not trip
        as_n = 1'b0; b = edges;
        wait_clks(int'(N) - 1);
        dtack_n = 1'b0;
        push(b + N + 3, 1'b1, "R3");
        push(b + N + 6, 1'b1, "R3");
        wait_clks(10);
        as_n = 1'b1; dtack_n = 1'b1;
        wait_clks(6);

        // R3: acknowledge at d = N trips
        as_n = 1'b0; b = edges;
        wait_clks(int'(N));
        dtack_n = 1'b0;
        push(b + N + 2, 1'b1, "R3");
        push(b + N + 3, 1'b0, "R3");
        wait_clks(8);
        as_n = 1'b1; dtack_n = 1'b1; b = edges;
        push(b + 3, 1'b1, "R3");
        wait_clks(6);

        // R7: reset clears an asserted bus error on the next edge
        as_n = 1'b0; b = edges;
        push(b + N + 3, 1'b0, "R7");
        wait_clks(int'(N) + 5);
        rst_n = 1'b0; b = edges;
        push(b + 1, 1'b1, "R7");
        push(b + 4, 1'b1, "R7");
        wait_clks(6);
        rst_n = 1'b1; as_n = 1'b1;
        wait_clks(4);

        while (sbq.size() > 0) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule